// File: doc/BRIEF.md
# Oversampling Serpentine Sample Buffer

This block sits at the front of a polyphase channelizer. It accepts one complex input sample per handshake and keeps a history of 16 x 8 = 128 samples. The history is arranged as 8 columns of 16 lanes and feeds a bank of 16 eight-tap filters. Every accepted sample moves the whole history one place along a single serpentine path. The new sample enters at the top of the first column. Each column's bottom lane spills into the top lane of the next column. The sample at the bottom of the last column is dropped.

A full output block is offered after every 14 accepted samples, not after every 16. Two lanes of the newest column therefore come from the previous block, and the output rate is 16/14 = 8/7 times the per-channel input rate. The stride is derived from the parameters as channels x decimation / interpolation. The first block is offered at the first 14-sample boundary at which the history has been completely refilled since reset. While a block waits for the filter bank to take it, the input is held off, so no sample is lost and the offered array does not change.

Top module: `serp_buffer`

## Requirements
- R1: After a synchronous reset, `blkValid` is 0, `inReady` is 1, and every lane of `blkData` is zero.
- R2: The sample accepted on a handshake appears in column 0, lane 15 on the next cycle. The sample accepted j handshakes before the newest sits at serpentine position j. Position p maps to column p/16, lane 15 - (p mod 16). Lane r of column k occupies `blkData` bits [(k*16+r)*32 +: 32].
- R3: On each accepted sample, the previous contents of column k lane 0 move to column k+1 lane 15, and every other lane moves down by one within its column.
- R4: The first `blkValid` rises on the cycle after the 140th accepted sample since reset. That is the first multiple of 14 that is at least 128.
- R5: After that, `blkValid` rises on the cycle after every further 14th accepted sample.
- R6: While `blkValid` is 1 and `blkReady` is 0, `inReady` is 0, `blkValid` stays 1, and `blkData` does not change.
- R7: `inReady` equals NOT `blkValid` OR `blkReady`. After a cycle with `blkValid` and `blkReady` both 1, `blkValid` is 0, and a sample may be accepted in that same cycle.
- R8: Only the 128 most recently accepted samples are held; older samples leave the array.
- R9: A cycle without an accepted sample leaves `blkData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample is present |
| inData | input | 32 | Complex input sample (16-bit I and Q) |
| inReady | output | 1 | Buffer can take a sample this cycle |
| blkValid | output | 1 | A complete block is offered |
| blkReady | input | 1 | Filter bank takes the block |
| blkData | output | 4096 | 8 columns x 16 lanes x 32 bits |

## Verification
The bench first streams samples back to back with the downstream always ready. This pins the 140-sample start and the 14-sample cadence, and it separates a stride of 14 from a stride of 16. Next, the input valid is gapped at random, which shows whether the position counters advance only on real handshakes. Random and then long downstream stalls follow; these expose any lost, repeated or moved sample while the block is held. A final idle stretch confirms that nothing moves without input. A behavioural history queue is compared against every lane on every cycle, so an error in the lane order or at a column boundary shows up at once.

// File: rtl/serp_pkg.sv
package serp_pkg;
  // Strobes from the control path to the datapath.
  typedef struct packed {
    logic shiftEn;  // advance the serpentine line by one sample
  } serpStrobes_t;
endpackage

// File: rtl/serp_ctrl.sv
module serp_ctrl
  import serp_pkg::*;
#(
  parameter int SHIFT = 14,
  parameter int DEPTH = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         blkReady,
  output logic         inReady,
  output logic         blkValid,
  output serpStrobes_t strobes
);
  localparam int GW = $clog2(SHIFT + 1);
  localparam int FW = $clog2(DEPTH + 1);

  logic [GW-1:0] grpCnt;
  logic [FW-1:0] fillCnt;
  logic          validQ;
  logic          accept;
  logic          lastInGroup;
  logic          filledNext;

  assign inReady     = !validQ || blkReady;
  assign accept      = inValid && inReady;
  assign lastInGroup = (grpCnt == GW'(SHIFT - 1));
  assign filledNext  = (fillCnt >= FW'(DEPTH - 1));
  assign blkValid    = validQ;
  assign strobes.shiftEn = accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      grpCnt  <= '0;
      fillCnt <= '0;
      validQ  <= 1'b0;
    end else begin
      if (accept) begin
        grpCnt <= lastInGroup ? '0 : grpCnt + 1'b1;
        if (fillCnt != FW'(DEPTH)) fillCnt <= fillCnt + 1'b1;
      end
      if (accept && lastInGroup && filledNext) validQ <= 1'b1;
      else if (blkReady)                      validQ <= 1'b0;
    end
  end
endmodule

// File: rtl/serp_datapath.sv
module serp_datapath
  import serp_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int TAPS   = 8,
  parameter int DW     = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  serpStrobes_t               strobes,
  input  logic [DW-1:0]              inData,
  output logic [NUM_CH*TAPS*DW-1:0]  blkData
);
  localparam int DEPTH = NUM_CH * TAPS;

  // Serpentine line: position 0 is the newest sample.
  logic [DW-1:0] line [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) line[i] <= '0;
    end else if (strobes.shiftEn) begin
      line[0] <= inData;
      for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
    end
  end

  // Column k, lane r holds line position k*NUM_CH + (NUM_CH-1-r).
  for (genvar k = 0; k < TAPS; k++) begin : g_col
    for (genvar r = 0; r < NUM_CH; r++) begin : g_lane
      assign blkData[(k*NUM_CH + r)*DW +: DW] = line[k*NUM_CH + NUM_CH - 1 - r];
    end
  end
endmodule

// File: rtl/serp_buffer.sv
module serp_buffer
  import serp_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int TAPS   = 8,
  parameter int UPF    = 8,
  parameter int DNF    = 7,
  parameter int DW     = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inValid,
  input  logic [DW-1:0]             inData,
  output logic                      inReady,
  output logic                      blkValid,
  input  logic                      blkReady,
  output logic [NUM_CH*TAPS*DW-1:0] blkData
);
  localparam int SHIFT = NUM_CH * DNF / UPF;
  localparam int DEPTH = NUM_CH * TAPS;

  serpStrobes_t strobes;

  serp_ctrl #(.SHIFT(SHIFT), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .blkReady(blkReady),
    .inReady(inReady), .blkValid(blkValid), .strobes(strobes)
  );

  serp_datapath #(.NUM_CH(NUM_CH), .TAPS(TAPS), .DW(DW)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .inData(inData), .blkData(blkData)
  );
endmodule

// File: rtl/serp_buffer_chk.sv
module serp_buffer_chk #(
  parameter int NUM_CH = 16,
  parameter int TAPS   = 8,
  parameter int DW     = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      inValid,
  input logic [DW-1:0]             inData,
  input logic                      inReady,
  input logic                      blkValid,
  input logic                      blkReady,
  input logic [NUM_CH*TAPS*DW-1:0] blkData
);
  logic [DW-1:0] col0Top, col0Bot, col1Top;
  assign col0Top = blkData[(NUM_CH-1)*DW +: DW];
  assign col0Bot = blkData[0 +: DW];
  assign col1Top = blkData[(2*NUM_CH-1)*DW +: DW];

  assert_newest_top_R2: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> (col0Top == $past(inData)));

  assert_column_spill_R3: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> (col1Top == $past(col0Bot)));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (blkValid && !blkReady) |=> (blkValid && $stable(blkData)));

  assert_release_R7: assert property (@(posedge clk) disable iff (rst)
    (blkValid && blkReady) |=> !blkValid);

  assert_idle_still_R9: assert property (@(posedge clk) disable iff (rst)
    !(inValid && inReady) |=> $stable(blkData));
endmodule

bind serp_buffer serp_buffer_chk #(.NUM_CH(NUM_CH), .TAPS(TAPS), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inReady(inReady),
  .blkValid(blkValid), .blkReady(blkReady), .blkData(blkData)
);

// File: tb/sim_serp_buffer.sv
`timescale 1ns/1ps
module sim_serp_buffer;
  localparam int NCH = 16, NTAP = 8, DW = 32, DEPTH = NCH * NTAP, STRIDE = 14;
  localparam int NCYC = 2600;

  logic clk = 1'b0;
  logic rst, inValid, blkReady, inReady, blkValid;
  logic [DW-1:0] inData;
  logic [DEPTH*DW-1:0] blkData;

  int nTests = 0, nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  serp_buffer u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inReady(inReady),
    .blkValid(blkValid), .blkReady(blkReady), .blkData(blkData)
  );

  // Reference model: newest sample at index 0.
  logic [DW-1:0] hist[$];
  bit expValid;
  int total;
  bit firstSeen;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmpData(input string tag);
    int bad;
    logic [DW-1:0] a, e;
    bad = -1;
    for (int k = 0; k < NTAP; k++)
      for (int r = 0; r < NCH; r++) begin
        a = blkData[(k*NCH + r)*DW +: DW];
        e = hist[k*NCH + NCH - 1 - r];
        if (bad < 0 && a !== e) bad = k*NCH + r;
      end
    if (bad < 0) chk(1'b1, tag, '0, '0);
    else chk(1'b0, $sformatf("%s lane %0d", tag, bad),
             blkData[bad*DW +: DW], hist[(bad/NCH)*NCH + NCH - 1 - (bad%NCH)]);
  endtask

  initial begin
    #(NCYC * 10 + 2000);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    bit expRdy, acc;
    logic [DW-1:0] s;
    rst = 1'b1; inValid = 1'b0; blkReady = 1'b0; inData = '0;
    for (int i = 0; i < DEPTH; i++) hist.push_back('0);
    expValid = 0; total = 0; firstSeen = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(blkValid == 1'b0, "R1 blkValid after reset", blkValid, 0);
    chk(inReady == 1'b1, "R1 inReady after reset", inReady, 1);
    chk(blkData == '0, "R1 blkData after reset", blkData[DW-1:0], 0);

    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      if (c < 400)        inValid = 1'b1;
      else if (c >= 2300 && c < 2400) inValid = 1'b0;
      else                inValid = (($urandom % 10) < 7);
      if (c < 1200)       blkReady = 1'b1;
      else if (c < 2000)  blkReady = (($urandom % 3) != 0);
      else                blkReady = (($urandom % 8) == 0);
      s = $urandom;
      inData = s;
      #1;
      expRdy = !expValid || blkReady;
      chk(blkValid == expValid, "R4/R5/R6/R7 blkValid", blkValid, expValid);
      chk(inReady == expRdy, "R6/R7 inReady", inReady, expRdy);
      cmpData("R2/R3/R8/R9 blkData");
      if (blkValid && !firstSeen) begin
        firstSeen = 1;
        chk(total == 140, "R4 accepted count at first block", total, 140);
      end
      acc = inValid && expRdy;
      if (acc) begin
        hist.push_front(s);
        void'(hist.pop_back());
        total++;
      end
      if (acc && (total % STRIDE == 0) && total >= DEPTH) expValid = 1;
      else if (blkReady) expValid = 0;
    end
    chk(firstSeen, "R4 a block was offered", firstSeen, 1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule